// File: doc/BRIEF.md
# Parallel Link Pattern Generator and Checker

This block exercises a wide parallel source-synchronous link between two boards. Its transmit half drives 23 data lanes, an even-parity lane and a forwarded clock. Each data lane carries its own 16-bit binary counter. The counter goes out one bit per link clock, most significant bit first, and every lane's counter steps by one after each 16-bit word. Because a whole counter value is serialised, lane patterns range from busy toggling down to a single mark in sixteen bits. This stresses the link with very uneven transition densities.

The receive half samples the same lanes whenever its sample-enable input is high. That input stands in for a sampling phase that is set outside the block. From the samples it rebuilds each lane's word stream. Each lane locks independently onto the incrementing sequence, then counts words that break it. A separate counter records every sampled bit period whose parity lane disagrees with the data. The counters are read through a small address/data port. A synchronous clear zeroes all counters and sends every lane back to acquisition.

Top module: `lpg_top`

## Requirements
- R1: After reset, lane i's transmit counter holds (i × 0x0101) mod 2^16, the transmit bit index is 0, no lane is locked, every counter reads 0 and err_any is low.
- R2: tx_data[i] shows bit (15 − b) of lane i's counter, where b is the transmit bit index. The index advances by one on each clock with tx_en high, and nothing changes while tx_en is low.
- R3: When the transmit bit index passes 15 it returns to 0, and every lane counter increments by one (mod 2^16).
- R4: tx_par is the XOR of the 23 tx_data bits (even parity), and tx_clk_fwd is the link clock.
- R5: The receiver acts only on clocks with rx_sample high. The 16th such sample since reset, clear or the previous word end closes a word, assembled most significant bit first. Samples taken with rx_sample low alter no counter and no lock state.
- R6: A lane treats its first word as a reference. It raises lane_lock[i] after two consecutive following words each equal the previous word + 1. A word that breaks the run during acquisition becomes the new reference and restarts the run.
- R7: Once locked, a lane increments its error counter by one for each word that differs from its expected value. The expected value advances by one per word whether or not the word matched.
- R8: Lane error counters and the parity error counter saturate at all ones.
- R9: Each sampled bit period where rx_par differs from the XOR of rx_data increments the parity error counter by one, independent of lane lock.
- R10: A high clr for one clock zeroes every counter, drops all lane locks and restarts the receive bit index at 0.
- R11: reg_rdata returns lane k's error count for reg_addr = k (0 to 22), the parity error count for reg_addr = 23, and 0 for any other address.
- R12: err_any is high exactly while at least one error counter is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and lock state |
| tx_en | input | 1 | Advance the transmit pattern by one bit |
| tx_data | output | 23 | Transmit data lanes |
| tx_par | output | 1 | Transmit even-parity lane |
| tx_clk_fwd | output | 1 | Forwarded clock |
| rx_sample | input | 1 | Receive sample enable (stands in for sampling phase) |
| rx_data | input | 23 | Received data lanes |
| rx_par | input | 1 | Received parity lane |
| reg_addr | input | 5 | Counter read address |
| reg_rdata | output | ERR_W (16) | Counter read data |
| lane_lock | output | 23 | Per-lane lock status |
| err_any | output | 1 | Any error counter non-zero |

## Verification
The transmit side runs under an irregular enable pattern, so held bits can be told apart from shifted ones and word boundaries fall on varied cycles. Parity is tried with a table of lane words with odd and even weight and with right and wrong parity. This shows that only true mismatches count. Receive streams are clean, have one corrupted lane, have a broken run during acquisition, and carry gaps of junk with the sample enable low. Together these separate lock timing, run restart, expected-value tracking and sample gating. Long runs of bad words and bad parity reach saturation.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_CHECK = 2'd2
    } lane_st_e;

    // Start value of a lane's counter: lane index times 0x0101
    function automatic logic [15:0] lane_seed(input int unsigned lane);
        return 16'(lane * 257);
    endfunction

endpackage

// File: rtl/lpg_tx.sv
module lpg_tx #(
    parameter int LANES  = 23,
    parameter int WORD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [LANES-1:0] data,
    output logic             par
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic [IDX_W-1:0]             idx;
        logic [LANES-1:0][WORD_W-1:0] cnt;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d = q;
        if (en) begin
            d.idx = q.idx + 1'b1;
            if (q.idx == IDX_LAST) begin
                d.idx = '0;
                for (int i = 0; i < LANES; i++) begin
                    d.cnt[i] = q.cnt[i] + WORD_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.idx <= '0;
            for (int i = 0; i < LANES; i++) begin
                q.cnt[i] <= WORD_W'(lpg_pkg::lane_seed(i));
            end
        end else begin
            q <= d;
        end
    end

    logic [LANES-1:0][WORD_W-1:0] shifted;
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            shifted[i] = q.cnt[i] << q.idx;
            data[i]    = shifted[i][WORD_W-1];
        end
        par = ^data;
    end

    // R3: a completed word steps the counter
    p_word_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.idx == IDX_LAST) |=> (q.cnt[0] == $past(q.cnt[0]) + WORD_W'(1)) && (q.idx == '0));

    // R2: nothing moves without enable
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q.idx) && $stable(q.cnt));

endmodule

// File: rtl/lpg_rx_frame.sv
module lpg_rx_frame #(
    parameter int LANES  = 23,
    parameter int WORD_W = 16,
    parameter int ERR_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp,
    input  logic [LANES-1:0] rx_data,
    input  logic             rx_par,
    output logic             word_end,
    output logic [ERR_W-1:0] par_err
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [ERR_W-1:0] perr;
    } fr_s;

    fr_s  q, d;
    logic bad_par;

    assign bad_par  = (^rx_data) != rx_par;
    assign word_end = smp && (q.idx == IDX_LAST);
    assign par_err  = q.perr;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (smp) begin
            d.idx = q.idx + 1'b1;
            if (bad_par && q.perr != '1) begin
                d.perr = q.perr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R9: parity count moves by at most one and never falls without clear
    p_par_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (q.perr >= $past(q.perr)) && (q.perr - $past(q.perr) <= ERR_W'(1)));

    // R5: no sample, no change
    p_no_smp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp && !clr) |=> $stable(q));

endmodule

// File: rtl/lpg_rx_lane.sv
module lpg_rx_lane #(
    parameter int WORD_W = 16,
    parameter int ERR_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp,
    input  logic             bit_in,
    input  logic             word_end,
    output logic [ERR_W-1:0] err_cnt,
    output logic             locked
);
    import lpg_pkg::*;

    typedef struct packed {
        lane_st_e          st;
        logic              mcnt;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] exp;
        logic [ERR_W-1:0]  err;
    } lane_s;

    lane_s             q, d;
    logic [WORD_W-1:0] word_w;
    logic [WORD_W-1:0] nxt_w;

    assign word_w  = {q.sh[WORD_W-2:0], bit_in};
    assign nxt_w   = q.exp + WORD_W'(1);
    assign err_cnt = q.err;
    assign locked  = (q.st == ST_CHECK);

    always_comb begin
        d = q;
        if (clr) begin
            d    = '0;
            d.st = ST_HUNT;
        end else if (smp) begin
            d.sh = word_w;
            if (word_end) begin
                case (q.st)
                    ST_HUNT: begin
                        d.exp  = word_w;
                        d.mcnt = 1'b0;
                        d.st   = ST_ACQ;
                    end
                    ST_ACQ: begin
                        d.exp = word_w;
                        if (word_w == nxt_w) begin
                            if (q.mcnt) begin
                                d.st = ST_CHECK;
                            end
                            d.mcnt = 1'b1;
                        end else begin
                            d.mcnt = 1'b0;
                        end
                    end
                    ST_CHECK: begin
                        d.exp = nxt_w;
                        if (word_w != nxt_w && q.err != '1) begin
                            d.err = q.err + 1'b1;
                        end
                    end
                    default: d.st = ST_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    // R6: lock appears only on a word boundary
    p_lock_on_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(word_end));

    // R7: errors only counted while locked, one per word
    p_err_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(word_end && locked)) |=> $stable(q.err));

    // R8: saturating counter never wraps
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> q.err >= $past(q.err));

    // R10: clear empties the lane
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.err == '0) && !locked);

endmodule

// File: rtl/lpg_top.sv
module lpg_top #(
    parameter int LANES  = 23,
    parameter int WORD_W = 16,
    parameter int ERR_W  = 16,
    parameter int ADDR_W = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tx_en,
    output logic [LANES-1:0]  tx_data,
    output logic              tx_par,
    output logic              tx_clk_fwd,
    input  logic              rx_sample,
    input  logic [LANES-1:0]  rx_data,
    input  logic              rx_par,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [ERR_W-1:0]  reg_rdata,
    output logic [LANES-1:0]  lane_lock,
    output logic              err_any
);
    localparam logic [ADDR_W-1:0] PAR_ADDR = ADDR_W'(LANES);

    logic                        word_end;
    logic [ERR_W-1:0]            par_err;
    logic [LANES-1:0][ERR_W-1:0] lane_err;
    logic [LANES-1:0]            lane_nz;

    assign tx_clk_fwd = clk;

    lpg_tx #(.LANES(LANES), .WORD_W(WORD_W)) tx_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tx_en),
        .data (tx_data),
        .par  (tx_par)
    );

    lpg_rx_frame #(.LANES(LANES), .WORD_W(WORD_W), .ERR_W(ERR_W)) frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .smp     (rx_sample),
        .rx_data (rx_data),
        .rx_par  (rx_par),
        .word_end(word_end),
        .par_err (par_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lpg_rx_lane #(.WORD_W(WORD_W), .ERR_W(ERR_W)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .smp     (rx_sample),
            .bit_in  (rx_data[g]),
            .word_end(word_end),
            .err_cnt (lane_err[g]),
            .locked  (lane_lock[g])
        );
        assign lane_nz[g] = |lane_err[g];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < PAR_ADDR) begin
            reg_rdata = lane_err[reg_addr];
        end else if (reg_addr == PAR_ADDR) begin
            reg_rdata = par_err;
        end
        err_any = (|lane_nz) || (|par_err);
    end

    // R12: flag low implies the parity counter is empty
    p_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !err_any |-> (par_err == '0));

    // R4: forwarded parity is even over the lanes
    p_tx_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ^{tx_data, tx_par} == 1'b0);

endmodule

// File: tb/lpg_top_tb_top.sv
module lpg_top_tb_top;
    localparam int LANES = 23;
    localparam int ERR_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             tx_en = 1'b0;
    logic [LANES-1:0] tx_data;
    logic             tx_par;
    logic             tx_clk_fwd;
    logic             rx_sample = 1'b0;
    logic [LANES-1:0] rx_data = '0;
    logic             rx_par = 1'b0;
    logic [4:0]       reg_addr = '0;
    logic [ERR_W-1:0] reg_rdata;
    logic [LANES-1:0] lane_lock;
    logic             err_any;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpg_top #(.LANES(LANES), .WORD_W(16), .ERR_W(ERR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tx_en(tx_en),
        .tx_data(tx_data), .tx_par(tx_par), .tx_clk_fwd(tx_clk_fwd),
        .rx_sample(rx_sample), .rx_data(rx_data), .rx_par(rx_par),
        .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .lane_lock(lane_lock), .err_any(err_any)
    );

    // data[22:0], parity, expected count increment
    localparam logic [24:0] PVEC [8] = '{
        {23'h000000, 1'b0, 1'b0},
        {23'h000001, 1'b0, 1'b1},
        {23'h000001, 1'b1, 1'b0},
        {23'h7FFFFF, 1'b1, 1'b0},
        {23'h7FFFFF, 1'b0, 1'b1},
        {23'h000003, 1'b0, 1'b0},
        {23'h400000, 1'b0, 1'b1},
        {23'h555555, 1'b0, 1'b0}
    };

    function automatic logic [15:0] mword(int lane, int k);
        return 16'(lane * 257 + k);
    endfunction

    function automatic logic [LANES-1:0] mlanes(int k, int b);
        logic [LANES-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            logic [15:0] w;
            w = mword(i, k);
            v[i] = w[15 - b];
        end
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 5'(a);
        #1;
        v = 32'(reg_rdata);
    endtask

    task automatic clear();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    // send word k on all lanes; bad_lane gets its first bit flipped; gap adds unsampled junk
    task automatic rx_word(int k, int bad_lane, bit gap);
        for (int b = 0; b < 16; b++) begin
            if (gap && b == 8) begin
                for (int g = 0; g < 3; g++) begin
                    rx_sample = 1'b0;
                    rx_data   = ~mlanes(k, b);
                    rx_par    = ~(^rx_data);
                    step();
                end
            end
            rx_sample = 1'b1;
            rx_data   = mlanes(k, b);
            if (b == 0 && bad_lane >= 0) rx_data[bad_lane] = ~rx_data[bad_lane];
            rx_par = ^rx_data;
            step();
        end
        rx_sample = 1'b0;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int ntx;
        int exp_p;

        @(negedge clk);
        step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1 tx_data", 32'(tx_data), 32'(mlanes(0, 0)));
        chk("R1 lock", 32'(lane_lock), 32'h0);
        chk("R1 err_any", 32'(err_any), 32'h0);
        rd(0, v);  chk("R1 lane0 count", v, 0);
        rd(23, v); chk("R1 parity count", v, 0);

        // R2 R3 R4: transmit pattern under irregular enable
        ntx = 0;
        for (int c = 0; c < 60; c++) begin
            tx_en = (c % 3 != 0);
            step();
            if (tx_en) ntx++;
            chk("R2 R3 tx lanes", 32'(tx_data), 32'(mlanes(ntx / 16, ntx % 16)));
            chk("R4 tx parity", 32'(tx_par), 32'(^mlanes(ntx / 16, ntx % 16)));
        end
        tx_en = 1'b0;
        chk("R4 fwd clock", 32'(tx_clk_fwd), 32'h0);

        // R9: parity table
        exp_p = 0;
        for (int t = 0; t < 8; t++) begin
            rx_sample = 1'b1;
            rx_data   = PVEC[t][24:2];
            rx_par    = PVEC[t][1];
            step();
            exp_p += int'(PVEC[t][0]);
            rx_sample = 1'b0;
            rd(23, v); chk("R9 parity table", v, 32'(exp_p));
        end
        chk("R12 flag on parity", 32'(err_any), 32'h1);

        // R10: clear
        clear();
        rd(23, v); chk("R10 parity cleared", v, 0);
        chk("R10 flag cleared", 32'(err_any), 32'h0);

        // R6: lock sequence
        rx_word(0, -1, 0);
        chk("R6 no lock after ref", 32'(lane_lock), 32'h0);
        rx_word(1, -1, 0);
        chk("R6 no lock after one match", 32'(lane_lock), 32'h0);
        rx_word(2, -1, 0);
        chk("R6 lock after two matches", 32'(lane_lock), 32'h7FFFFF);

        // R7 R5: one corrupt lane, with unsampled junk mid-word
        rx_word(3, 5, 1);
        rd(5, v);  chk("R7 lane5 error", v, 1);
        rd(6, v);  chk("R7 lane6 clean", v, 0);
        rd(23, v); chk("R5 junk not sampled", v, 0);
        rx_word(4, -1, 1);
        rd(5, v);  chk("R7 expected advanced", v, 1);
        chk("R5 lock kept through gaps", 32'(lane_lock), 32'h7FFFFF);
        chk("R12 flag on lane error", 32'(err_any), 32'h1);
        rd(30, v); chk("R11 unmapped address", v, 0);

        // R10: clear drops lock and counters
        clear();
        chk("R10 lock dropped", 32'(lane_lock), 32'h0);
        rd(5, v); chk("R10 lane5 cleared", v, 0);

        // R6: broken run restarts acquisition
        rx_word(10, -1, 0);
        rx_word(11, -1, 0);
        rx_word(20, -1, 0);
        rx_word(21, -1, 0);
        chk("R6 restart not yet locked", 32'(lane_lock), 32'h0);
        rx_word(22, -1, 0);
        chk("R6 restart locked", 32'(lane_lock), 32'h7FFFFF);

        // R8: saturation of a lane counter
        for (int k = 23; k < 323; k++) rx_word(k, 7, 0);
        rd(7, v); chk("R8 lane saturates", v, 255);
        rd(8, v); chk("R8 other lane clean", v, 0);

        // R8 R9: parity counter saturates
        clear();
        for (int c = 0; c < 300; c++) begin
            rx_sample = 1'b1;
            rx_data   = '0;
            rx_par    = 1'b1;
            step();
        end
        rx_sample = 1'b0;
        rd(23, v); chk("R8 R9 parity saturates", v, 255);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule